// File: doc/BRIEF.md
# Synchronized Shadow Register Commit Controller

This block holds a bank of control registers in two copies. A host writes the shadow copy through a simple address, data and write-enable port at any time. The active copy, the one the downstream core reads, changes only when an external update request is recognised, and then every register is replaced at once from the shadow copy.

The system clock is divided by four into a slower synchronization clock, which is driven out so that external logic can time its update requests against it. The update request is sampled only at rising edges of that divided clock. It passes through a two-stage synchronizer and a rising-edge detector, and the detector issues a commit strobe that is one system clock wide. Because sampling, synchronizing and detecting all happen on divided-clock edges, the number of system cycles from the sampling edge to the active copy changing is always the same.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: `sync_clk_o` repeats every 4 system cycles, high for 2 and low for 2. It rises on the second system clock edge after reset is released.
- R2: `upd_i` is sampled only on system edges where `sync_clk_o` rises. A high pulse that starts and ends between two such edges causes no commit.
- R3: A commit copies every shadow register into the active bank on one system edge. That edge comes exactly 8 system cycles after the `sync_clk_o` rising edge that first sampled `upd_i` high. Register i is driven on `active_o[i*DW +: DW]`.
- R4: Holding `upd_i` high for any length of time causes exactly one commit. Later shadow writes stay out of the active bank while it is held high.
- R5: A new commit needs `upd_i` to be sampled low on at least one `sync_clk_o` rising edge. A low that no such edge sees does not re-arm the detector.
- R6: A write with `wr_en_i` high stores `wr_data_i` into shadow register `wr_addr_i` and leaves `active_o` unchanged.
- R7: With `rst_n` low, the divider, the synchronizer, the edge history, the shadow bank and the active bank clear to zero, and `sync_clk_o` and `active_o` read 0.
- R8: If a shadow write lands on the same system edge as a commit, the commit takes the value from before that write. The written value reaches the active bank at the next commit.
- R9: The internal commit strobe is never high for two system cycles in a row, and it fires only on a system edge where `sync_clk_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sync_clk_o | output | 1 | Divide-by-four synchronization clock |
| upd_i | input | 1 | External update request |
| wr_en_i | input | 1 | Shadow write enable |
| wr_addr_i | input | AW (2) | Shadow register index |
| wr_data_i | input | DW (16) | Shadow write data |
| active_o | output | NREG*DW (64) | Active register bank, flattened |

## Verification
A shadow write shows in the active bank only after a commit, so the bench reads the write's effect back through `active_o` after the commit. The bench always raises `upd_i` on the falling system edge that follows a `sync_clk_o` rise. The rising edge 3.5 cycles later samples it, so the commit is due on the system edge 11.5 cycles after the raise. The bench samples `active_o` on the falling edges just before and just after that edge, one showing the old contents and one the new. Checks that something must not happen are made at least 16 cycles after the stimulus, which is two full sampling-to-commit latencies. Divider timing is measured by counting falling system edges between `sync_clk_o` transitions.

// File: rtl/shcm_pkg.sv
package shcm_pkg;
  // Width of a counter that runs from 0 to ratio-1.
  function automatic int cnt_width(input int ratio);
    return (ratio > 2) ? $clog2(ratio) : 1;
  endfunction

  // Wrapping increment for the divider.
  function automatic int wrap_inc(input int cur, input int ratio);
    return (cur == ratio - 1) ? 0 : cur + 1;
  endfunction

  // Number of system cycles from the sampling edge to the commit edge.
  function automatic int commit_latency(input int ratio, input int stages);
    return ratio * stages;
  endfunction
endpackage

// File: rtl/shcm_sync_div.sv
module shcm_sync_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_clk,
  output logic rise_tick
);
  import shcm_pkg::*;
  localparam int CW   = cnt_width(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          sync_q;

  always_comb begin
    cnt_nxt = CW'(wrap_inc(int'(cnt_q), DIV));
  end

  // The divided clock rises on the edge that moves the counter from HALF-1 to HALF.
  assign rise_tick = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      sync_q <= (cnt_nxt >= CW'(HALF));
    end
  end

  assign sync_clk = sync_q;
endmodule

// File: rtl/shcm_edge_det.sv
module shcm_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_i,
  output logic strobe_o
);
  logic [STAGES-1:0] pipe_q;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pipe_q <= '0;
        else if (tick) pipe_q <= req_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pipe_q <= '0;
        else if (tick) pipe_q <= {pipe_q[STAGES-2:0], req_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= 1'b0;
    else if (tick) hist_q <= pipe_q[STAGES-1];
  end

  // The rise is held for one divided period; gating with tick makes it one system cycle.
  assign strobe_o = tick & pipe_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/shcm_bank.sv
module shcm_bank #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              commit,
  output logic [NREG*DW-1:0] active_flat
);
  logic [DW-1:0] shadow_q [NREG];
  logic [DW-1:0] active_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              shadow_q[g] <= '0;
      else if (wr_en && (wr_addr == AW'(g)))   shadow_q[g] <= wr_data;
    end

    // Non-blocking transfer: a same-edge write is not seen by this commit.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q[g] <= '0;
      else if (commit) active_q[g] <= shadow_q[g];
    end

    assign active_flat[g*DW +: DW] = active_q[g];
  end
endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl #(
  parameter int NREG   = 4,
  parameter int DW     = 16,
  parameter int DIV    = 4,
  parameter int STAGES = 2,
  parameter int AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk_sys_i,
  input  logic               rst_n,
  output logic               sync_clk_o,
  input  logic               upd_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  output logic [NREG*DW-1:0] active_o
);
  logic tick;
  logic commit_stb;

  shcm_sync_div #(.DIV(DIV)) u_div (
    .clk(clk_sys_i), .rst_n(rst_n), .sync_clk(sync_clk_o), .rise_tick(tick)
  );

  shcm_edge_det #(.STAGES(STAGES)) u_edge (
    .clk(clk_sys_i), .rst_n(rst_n), .tick(tick), .req_i(upd_i), .strobe_o(commit_stb)
  );

  shcm_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
    .clk(clk_sys_i), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .commit(commit_stb), .active_flat(active_o)
  );
endmodule

// File: rtl/shcm_checker.sv
module shcm_checker #(
  parameter int NREG = 4,
  parameter int DW   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_clk,
  input logic               tick,
  input logic               commit_stb,
  input logic [NREG*DW-1:0] active
);
  // R1: the divided clock rises right after each rise tick.
  p_sync_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> $rose(sync_clk));
  // R1: the divided clock never rises without a preceding tick.
  p_sync_rise_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_clk) |-> $past(tick));
  // R9: the strobe is one system cycle wide.
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);
  // R9 / R2: commits occur only on divided-clock rising edges.
  p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> tick);
  // R6: the active bank holds except after a commit.
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_stb |=> $stable(active));
  // R7: reset state of the outputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_state_r7: assert (active == '0 && sync_clk == 1'b0);
    end
  end
endmodule

bind shadow_commit_ctrl shcm_checker #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk_sys_i), .rst_n(rst_n), .sync_clk(sync_clk_o), .tick(tick),
  .commit_stb(commit_stb), .active(active_o)
);

// File: tb/shadow_commit_ctrl_test.sv
module shadow_commit_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int AW   = 2;
  localparam int LAT_FROM_RAISE = 12; // first falling edge after the commit edge

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic sync_clk;
  logic [NREG*DW-1:0] active;

  logic [DW-1:0] shadow_m [NREG];
  logic [DW-1:0] active_m [NREG];

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  shadow_commit_ctrl #(.NREG(NREG), .DW(DW)) uut (
    .clk_sys_i(clk), .rst_n(rst_n), .sync_clk_o(sync_clk), .upd_i(upd),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .active_o(active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NREG*DW-1:0] model_flat();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = active_m[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [NREG*DW-1:0] act,
                       input logic [NREG*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      summary();
    end
  end

  // Drive a write on a falling edge; it is stored on the following rising edge.
  task automatic drive_write(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    shadow_m[a] = d;
  endtask

  task automatic write_reg(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    drive_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic align();
    @(posedge sync_clk);
    @(negedge clk);
  endtask

  // Raise upd, hold for 'hold' falling edges, check commit timing (R3),
  // optionally write on the commit edge (R8) or after it (R4).
  task automatic do_update(input int hold, input bit same_edge_wr, input bit late_wr);
    logic [DW-1:0] pre [NREG];
    int last;
    align();
    upd = 1'b1;
    last = ((hold > LAT_FROM_RAISE) ? hold : LAT_FROM_RAISE) + 8;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (wr_en) wr_en = 1'b0;
      if (k == hold) upd = 1'b0;
      if (k == LAT_FROM_RAISE - 1) begin
        check("R3 before commit edge", active, model_flat());
        for (int i = 0; i < NREG; i++) pre[i] = shadow_m[i];
        if (same_edge_wr) drive_write(1, ~shadow_m[1]);
      end
      if (k == LAT_FROM_RAISE) begin
        for (int i = 0; i < NREG; i++) active_m[i] = pre[i];
        check(same_edge_wr ? "R8 commit took pre-write value" : "R3 commit after 8 cycles",
              active, model_flat());
      end
      if (late_wr && k == LAT_FROM_RAISE + 2) drive_write(2, shadow_m[2] ^ 16'h5A5A);
    end
    check(hold > LAT_FROM_RAISE ? "R4 single commit while held" : "R3 stable after commit",
          active, model_flat());
  endtask

  initial begin
    int hi_cnt;
    int lo_cnt;
    int rise_edge;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREG; i++) begin shadow_m[i] = '0; active_m[i] = '0; end

    repeat (3) @(negedge clk);
    check("R7 reset active zero", active, '0);
    check("R7 reset sync low", {63'd0, sync_clk}, '0);
    rst_n = 1'b1;

    // R1: first rise on second edge after release, then 2 high / 2 low.
    rise_edge = 0;
    for (int k = 1; k <= 4 && rise_edge == 0; k++) begin
      @(negedge clk);
      if (sync_clk) rise_edge = k;
    end
    check("R1 first rise edge", 64'(rise_edge), 64'd2);
    hi_cnt = 0; lo_cnt = 0;
    align();
    for (int k = 0; k < 8; k++) begin
      if (sync_clk) hi_cnt++; else lo_cnt++;
      @(negedge clk);
    end
    check("R1 high count", 64'(hi_cnt), 64'd4);
    check("R1 low count", 64'(lo_cnt), 64'd4);

    // R6: writes alone leave the active bank unchanged.
    for (int i = 0; i < NREG; i++) write_reg(i, DW'(16'h1100 + i));
    repeat (16) @(negedge clk);
    check("R6 writes do not reach active", active, model_flat());

    // R3: basic commit.
    do_update(5, 1'b0, 1'b0);

    // R2: short pulse between sampling edges is ignored.
    write_reg(0, 16'hBEEF);
    align();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (16) @(negedge clk);
    check("R2 unsampled pulse ignored", active, model_flat());

    // R4: long hold with a later write.
    do_update(40, 1'b0, 1'b1);

    // R8: write on the commit edge, then next commit brings it.
    do_update(6, 1'b1, 1'b0);
    do_update(6, 1'b0, 1'b0);
    check("R8 later commit carries write", active, model_flat());

    // R5: low not seen by a sampling edge does not re-arm.
    align();
    upd = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (wr_en) wr_en = 1'b0;
      if (k == LAT_FROM_RAISE) begin
        for (int i = 0; i < NREG; i++) active_m[i] = shadow_m[i];
        check("R5 first commit", active, model_flat());
      end
      if (k == 13) begin upd = 1'b0; drive_write(3, 16'hC0DE); end
      if (k == 14) upd = 1'b1;
    end
    check("R5 glitch low did not re-arm", active, model_flat());
    upd = 1'b0;
    repeat (8) @(negedge clk);
    do_update(4, 1'b0, 1'b0);
    check("R5 re-armed after sampled low", active, model_flat());

    // Random rounds.
    for (int r = 0; r < 20; r++) begin
      int nw;
      nw = 1 + int'($urandom_range(4));
      for (int w = 0; w < nw; w++)
        write_reg(int'($urandom_range(NREG-1)), DW'($urandom));
      repeat (2) @(negedge clk);
      check("R6 random writes held back", active, model_flat());
      do_update(4 + int'($urandom_range(20)), 1'($urandom_range(1)), 1'b0);
    end

    // R7: reset again clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 reset clears active", active, '0);
    summary();
  end
endmodule